// File: doc/BRIEF.md
# Programmable Divide-by-2/3 Cell Chain

This block divides a fast clock by a programmable integer using a row of identical divide-by-2/3 cells. Each cell passes one output tick to the following cell for every two of its own input ticks. When asked, it stretches a cycle by one more input tick. The cell nearest the input runs on every clock. Each later cell runs on the ticks of the cell before it. The cells run on clock enables inside one clock domain.

A cell only stretches a cycle when its program bit is set and the later cell grants it. That grant arrives on the mod-in input and comes from the mod-out register of the later cell. Each cell retimes its own mod-out and hands it back to the earlier cell. No gate has to watch the outputs of every stage at once. The mod-in of the last cell is held active. The mod-out of the first cell is the divided output: a single-clock pulse once per output period.

The program word is captured when a period starts. A change that arrives partway through a period therefore takes effect at the next period.

Top module: `mod23_chain`

## Requirements
- R1: With NCELL cells and program word P (bit i has weight 2^i, bit 0 belongs to the cell nearest the input), the output pulse repeats every 2^NCELL + P clock cycles. With the default of three cells this spans 8 to 15.
- R2: `div_o` is high for exactly one clock cycle in each output period.
- R3: A change of `prog_i` inside a period does not affect that period. Every interval between output pulses equals either the old or the new period length, and the period after the change uses the new value.
- R4: While `rst_n` is low, `div_o` is low. After release with a steady program word, the first pulse is visible after 2^NCELL + P - 1 rising clock edges.
- R5: The mod-in of the last cell is always active. A cell's mod-out is raised only while its mod-in is active, and it drops at the next input tick of that cell, so it lasts exactly one of that cell's input periods.
- R6: A cell enters its third (swallow) state only when its program bit and its mod-in are both active. With a program word of zero, no cell ever swallows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_i | input | NCELL | Program word P; period is 2^NCELL + P |
| div_o | output | 1 | One-cycle pulse per output period |

## Verification
The hardest case is a program change that lands partway through a period. From the ports this looks the same as a pulse train with a correct length, so the bench lines it up on purpose. It locks onto an output pulse, waits a few cycles into the next period, and then changes the word. It then checks that the interval in progress keeps the old length and that the following interval takes the new one. The case of a swallow that has to pass back through every cell is reached by sweeping all program words, including the all-ones word.

// File: rtl/mod23_pkg.sv
package mod23_pkg;
    localparam int CNT_W = 2;

    localparam logic [CNT_W-1:0] CNT_FIRST = 2'd0;
    localparam logic [CNT_W-1:0] CNT_END2  = 2'd1;
    localparam logic [CNT_W-1:0] CNT_END3  = 2'd2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mod;
    } cell_st_t;
endpackage

// File: rtl/mod23_cell.sv
module mod23_cell
    import mod23_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic pbit_i,
    input  logic modin_i,
    output logic tick_o,
    output logic modout_o
);
    cell_st_t st_d, st_q;
    logic     swallow;
    logic [CNT_W-1:0] end_cnt;
    logic     at_end;

    always_comb begin
        swallow = pbit_i & modin_i;
        end_cnt = swallow ? CNT_END3 : CNT_END2;
        at_end  = (st_q.cnt == end_cnt);
        tick_o  = tick_i & at_end;
        st_d    = st_q;
        if (tick_i) begin
            st_d.cnt = at_end ? CNT_FIRST : st_q.cnt + 1'b1;
            st_d.mod = modin_i && (st_d.cnt == end_cnt);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt: CNT_FIRST, mod: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign modout_o = st_q.mod;

    // R6: the third state is reachable only with a qualified swallow
    a_r6_swallow_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_END3) |-> (pbit_i && modin_i));

    // R5: mod-out only under an active mod-in
    a_r5_modout_needs_modin: assert property (@(posedge clk) disable iff (!rst_n)
        modout_o |-> modin_i);

    // R5: mod-out lasts a single input period of this cell
    a_r5_modout_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (modout_o && tick_i) |=> !modout_o);
endmodule

// File: rtl/mod23_chain.sv
module mod23_chain #(
    parameter int NCELL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCELL-1:0] prog_i,
    output logic             div_o
);
    localparam int PERIOD_MIN = 1 << NCELL;

    typedef struct packed {
        logic [NCELL-1:0] prog;
        logic             first;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic [NCELL:0]   tick;
    logic [NCELL:0]   mod;
    logic [NCELL-1:0] prog_eff;
    logic             wrap;

    assign tick[0]    = 1'b1;
    assign mod[NCELL] = 1'b1;
    assign wrap       = tick[NCELL];

    always_comb begin
        prog_eff = st_q.first ? prog_i : st_q.prog;
        st_d     = st_q;
        if (st_q.first || wrap) begin
            st_d.prog = prog_i;
        end
        st_d.first = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{prog: '0, first: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar gi = 0; gi < NCELL; gi++) begin : g_cell
        mod23_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (tick[gi]),
            .pbit_i   (prog_eff[gi]),
            .modin_i  (mod[gi+1]),
            .tick_o   (tick[gi+1]),
            .modout_o (mod[gi])
        );
    end

    assign div_o = mod[0];

    // R2: output pulse never lasts beyond one cycle
    a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        div_o |=> !div_o);

    // R3: the captured word only moves at a period boundary
    a_r3_prog_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && !st_q.first) |=> $stable(st_q.prog));

    // R1: the shortest legal period is at least two cycles
    initial a_r1_min_period: assert (PERIOD_MIN >= 2);
endmodule

// File: tb/sim_mod23_chain.sv
module sim_mod23_chain;
    localparam int NCELL = 3;
    localparam int BASE  = 1 << NCELL;
    localparam int NV    = 1 << NCELL;
    localparam int EXP_LEN [NV] = '{8, 9, 10, 11, 12, 13, 14, 15};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NCELL-1:0] prog = '0;
    logic             div_o;
    int               n_chk = 0;
    int               n_bad = 0;

    always #2 clk = ~clk;

    mod23_chain #(.NCELL(NCELL)) u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .prog_i (prog),
        .div_o  (div_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // count negedges from the current pulse to the next one
    task automatic next_interval(output int len);
        int k = 0;
        while (!div_o) @(negedge clk);
        do begin
            @(negedge clk);
            k++;
        end while (!div_o);
        len = k;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        report();
    end

    initial begin
        int len;
        int k;
        prog = 3'd5;
        repeat (3) @(negedge clk);
        // R4: output held low in reset
        check("R4 low in reset", int'(div_o), 0);
        rst_n = 1'b1;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!div_o && k < 40);
        // R4: first pulse after 2^NCELL + P - 1 edges
        check("R4 first pulse edge", k, BASE + 5 - 1);

        // R1 R5 R6: sweep every program value from the vector table
        for (int v = 0; v < NV; v++) begin
            prog = v[NCELL-1:0];
            next_interval(len);
            check($sformatf("R1 prog=%0d first", v), len, EXP_LEN[v]);
            next_interval(len);
            check($sformatf("R1 R5 prog=%0d second", v), len, EXP_LEN[v]);
            @(negedge clk);
            // R2: pulse is gone one cycle later
            check("R2 pulse width", int'(div_o), 0);
        end

        // R6: zero word means no swallow at all
        prog = '0;
        next_interval(len);
        next_interval(len);
        check("R6 no swallow at zero", len, BASE);

        // R3: change inside a period
        next_interval(len);
        k = 0;
        repeat (3) begin
            @(negedge clk);
            k++;
        end
        prog = '1;
        while (!div_o) begin
            @(negedge clk);
            k++;
        end
        check("R3 period in flight keeps old word", k, BASE);
        next_interval(len);
        check("R3 next period uses new word", len, BASE + NV - 1);

        // R3: change back, late in the period
        k = 0;
        repeat (10) begin
            @(negedge clk);
            k++;
        end
        prog = 3'd2;
        while (!div_o) begin
            @(negedge clk);
            k++;
        end
        check("R3 late change no runt", k, BASE + NV - 1);
        next_interval(len);
        check("R3 new word after late change", len, BASE + 2);

        // R4: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        prog = 3'd0;
        repeat (2) @(negedge clk);
        check("R4 low in second reset", int'(div_o), 0);
        rst_n = 1'b1;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!div_o && k < 40);
        check("R4 first pulse at zero word", k, BASE - 1);

        report();
    end
endmodule